// File: doc/BRIEF.md
# Programmable IDE Command Strobe Sequencer

This block times the command strobes of one local-bus IDE access. It holds two timing sets, A and B, and each set has four fields. The first gives how long the address must settle before a command strobe. The second gives how long a read strobe stays low and the third how long a write strobe stays low. The fourth gives the minimum time both strobes stay high after an access before the next one may start.

A requester holds `req` high with a direction flag and a set select until `ack` answers. On acceptance the block captures the chosen set's codes. It then counts the address setup clocks, drives the active-low read or write strobe, and counts out recovery with both strobes high. Only then does it drop `busy` and take the next request.

Setup counting can start at one of two points. In the default case it starts as soon as the request is accepted, which is when the default address and chip-select values appear. When the CPU supplies the address bit itself (`trig_t1` high), counting waits for a pulse on `t1_start`, which marks the start of the first bus state.

Top module: `ide_cmd_timer`

## Requirements
- R1: After reset, `rd_n` and `wr_n` are high, and `busy` and `ack` are low.
- R2: With `req_sel` = 0 the access uses set A (`set_a_sr`, `set_a_pw`), and with `req_sel` = 1 it uses set B. The codes are captured on the accepting edge, so later changes to either set do not affect an access already in progress.
- R3: With `trig_t1` low, a setup code n (bits [6:5] of the set's `*_sr` word) keeps both strobes high for n+1 clocks after the accepting edge, and then the strobe falls.
- R4: For a read (`req_wr` = 0), `rd_n` is low for exactly n+1 clocks, where n is bits [3:0] of the set's `*_pw` word. `wr_n` stays high throughout.
- R5: For a write (`req_wr` = 1), `wr_n` is low for exactly n+1 clocks, where n is bits [7:4] of the set's `*_pw` word. `rd_n` stays high throughout.
- R6: After the strobe rises, both strobes stay high and `busy` stays high for exactly n+1 clocks, where n is the recovery code in bits [3:0] of the set's `*_sr` word. `busy` then falls.
- R7: With `trig_t1` high at acceptance, the block stays busy with both strobes high until a clock edge sees `t1_start` high. The n+1 setup clocks begin after that edge.
- R8: `ack` is high exactly when the block is idle and `req` is high. A request raised while the block is busy is not dropped: it is accepted in the first idle cycle after recovery ends.
- R9: Bit 4 of each `*_sr` word is spare and has no effect on any output.
- R10: `busy` is high from the clock after acceptance until recovery ends, and it is low whenever `ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_a_sr | input | 7 | Set A recovery [3:0], spare [4], setup [6:5] |
| set_a_pw | input | 8 | Set A read width [3:0], write width [7:4] |
| set_b_sr | input | 7 | Set B recovery, spare and setup fields, same layout as set A |
| set_b_pw | input | 8 | Set B read and write widths, same layout as set A |
| trig_t1 | input | 1 | 1: setup counting waits for `t1_start` |
| t1_start | input | 1 | Marks the start of the first bus state |
| req | input | 1 | Access request, held until acknowledged |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = set A, 1 = set B |
| ack | output | 1 | Request accepted this cycle |
| busy | output | 1 | Access or recovery in progress |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
`ack` follows `req` in the same cycle, while the strobes and `busy` are registered and change one edge after the state that causes them. The bench samples everything at the falling edge, so a value seen there reflects the edges before it. In the directed tests, the first falling edge after acceptance counts as setup clock one. Strobe-low clocks and recovery clocks are counted the same way, and each count must equal its code plus one. A behavioural model advances on each rising edge and is compared with all four outputs at every falling edge. This catches off-by-one errors in any phase, and also catches late or early acceptance of a held request.

// File: rtl/ide_cmd_timer.sv
module ide_cmd_timer #(
  parameter int REC_W = 4,
  parameter int SET_W = 2,
  parameter int PW_W  = 4,
  localparam int SR_W = REC_W + 1 + SET_W,
  localparam int PWD_W = 2 * PW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SR_W-1:0]  set_a_sr,
  input  logic [PWD_W-1:0] set_a_pw,
  input  logic [SR_W-1:0]  set_b_sr,
  input  logic [PWD_W-1:0] set_b_pw,
  input  logic             trig_t1,
  input  logic             t1_start,
  input  logic             req,
  input  logic             req_wr,
  input  logic             req_sel,
  output logic             ack,
  output logic             busy,
  output logic             rd_n,
  output logic             wr_n
);
  localparam int CW0 = (REC_W > PW_W) ? REC_W : PW_W;
  localparam int CW  = (CW0 > SET_W) ? CW0 : SET_W;

  typedef enum logic [2:0] {S_IDLE, S_TRIG, S_SETUP, S_STB, S_REC} st_t;

  st_t st, nst;
  logic [CW-1:0]    cnt, ncnt;
  logic [REC_W-1:0] l_rec;
  logic [SET_W-1:0] l_set;
  logic [PW_W-1:0]  l_wid;
  logic             l_wr;

  wire [SR_W-1:0]  cur_sr = req_sel ? set_b_sr : set_a_sr;
  wire [PWD_W-1:0] cur_pw = req_sel ? set_b_pw : set_a_pw;
  wire [SET_W-1:0] cur_set = cur_sr[SR_W-1:REC_W+1];
  wire [PW_W-1:0]  cur_wid = req_wr ? cur_pw[PWD_W-1:PW_W] : cur_pw[PW_W-1:0];
  wire unused_spare = ^{set_a_sr[REC_W], set_b_sr[REC_W]};

  assign ack  = (st == S_IDLE) && req;
  assign busy = (st != S_IDLE);

  always_comb begin
    nst  = st;
    ncnt = cnt;
    case (st)
      S_IDLE:
        if (req) begin
          if (trig_t1) nst = S_TRIG;
          else begin
            nst  = S_SETUP;
            ncnt = CW'(cur_set);
          end
        end
      S_TRIG:
        if (t1_start) begin
          nst  = S_SETUP;
          ncnt = CW'(l_set);
        end
      S_SETUP:
        if (cnt == '0) begin
          nst  = S_STB;
          ncnt = CW'(l_wid);
        end else ncnt = cnt - CW'(1);
      S_STB:
        if (cnt == '0) begin
          nst  = S_REC;
          ncnt = CW'(l_rec);
        end else ncnt = cnt - CW'(1);
      S_REC:
        if (cnt == '0) nst = S_IDLE;
        else ncnt = cnt - CW'(1);
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      l_rec <= '0;
      l_set <= '0;
      l_wid <= '0;
      l_wr  <= 1'b0;
      rd_n  <= 1'b1;
      wr_n  <= 1'b1;
    end else begin
      st  <= nst;
      cnt <= ncnt;
      if (ack) begin
        l_rec <= cur_sr[REC_W-1:0];
        l_set <= cur_set;
        l_wid <= cur_wid;
        l_wr  <= req_wr;
      end
      rd_n <= !(nst == S_STB && !l_wr);
      wr_n <= !(nst == S_STB && l_wr);
    end
  end
endmodule

// File: rtl/ide_cmd_timer_chk.sv
module ide_cmd_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic ack,
  input logic busy,
  input logic rd_n,
  input logic wr_n
);
  a_r10_idle_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !busy);
  a_r10_busy_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> busy);
  a_r4_read_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (busy && wr_n));
  a_r5_write_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (busy && rd_n));
  a_r6_rise_into_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) || $rose(wr_n)) |-> busy);
  a_r3_setup_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n)) |-> ($past(busy) && $past(rd_n) && $past(wr_n)));
endmodule

bind ide_cmd_timer ide_cmd_timer_chk u_chk (.*);

// File: tb/ide_cmd_timer_test.sv
module ide_cmd_timer_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic [6:0] set_a_sr = '0, set_b_sr = '0;
  logic [7:0] set_a_pw = '0, set_b_pw = '0;
  logic trig_t1 = 0, t1_start = 0, req = 0, req_wr = 0, req_sel = 0;
  logic ack, busy, rd_n, wr_n;

  int checks = 0, fails = 0;
  bit done = 0;

  ide_cmd_timer uut (.*);

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference
  int ph = 0, left = 0, m_set = 0, m_wid = 0, m_rec = 0;
  bit mw = 0;
  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else case (ph)
      0: if (req) begin
           mw    = req_wr;
           m_set = req_sel ? set_b_sr[6:5] : set_a_sr[6:5];
           m_rec = req_sel ? set_b_sr[3:0] : set_a_sr[3:0];
           m_wid = req_sel ? (req_wr ? set_b_pw[7:4] : set_b_pw[3:0])
                           : (req_wr ? set_a_pw[7:4] : set_a_pw[3:0]);
           if (trig_t1) ph = 1; else begin ph = 2; left = m_set + 1; end
         end
      1: if (t1_start) begin ph = 2; left = m_set + 1; end
      2: begin left--; if (left == 0) begin ph = 3; left = m_wid + 1; end end
      3: begin left--; if (left == 0) begin ph = 4; left = m_rec + 1; end end
      default: begin left--; if (left == 0) ph = 0; end
    endcase
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R10 busy vs model", busy, ph != 0);
    chk("R8 ack vs model", ack, (ph == 0) && req);
    chk("R4 rd_n vs model", rd_n, !(ph == 3 && !mw));
    chk("R5 wr_n vs model", wr_n, !(ph == 3 && mw));
  end

  task automatic measure_rest(output int s, output int w, output int r, output bit strobe_rd);
    s = 0; w = 0; r = 0;
    while (rd_n && wr_n && busy) begin s++; @(negedge clk); end
    strobe_rd = !rd_n;
    while (!rd_n || !wr_n) begin w++; @(negedge clk); end
    while (busy) begin r++; @(negedge clk); end
  endtask

  task automatic access(input bit sel, input bit wr, input int cs, input int cw, input int cr,
                        input bit perturb, input string tag);
    int s, w, r;
    bit srd;
    logic [6:0] sa; logic [7:0] pa;
    while (busy) @(negedge clk);
    req = 1; req_sel = sel; req_wr = wr;
    #1 chk({tag, " R8 ack on idle request"}, ack, 1);
    @(negedge clk);
    req = 0;
    sa = set_a_sr; pa = set_a_pw;
    if (perturb) begin set_a_sr = ~set_a_sr; set_a_pw = ~set_a_pw; end
    measure_rest(s, w, r, srd);
    chk({tag, " R3 setup clocks"}, s, cs + 1);
    chk({tag, wr ? " R5 write strobe used" : " R4 read strobe used"}, srd, !wr);
    chk({tag, wr ? " R5 write width" : " R4 read width"}, w, cw + 1);
    chk({tag, " R6 recovery clocks"}, r, cr + 1);
    if (perturb) begin set_a_sr = sa; set_a_pw = pa; end
  endtask

  initial begin
    int n, s, w, r;
    bit srd;
    repeat (3) @(negedge clk);
    chk("R1 rd_n reset", rd_n, 1);
    chk("R1 wr_n reset", wr_n, 1);
    chk("R1 busy reset", busy, 0);
    chk("R1 ack reset", ack, 0);
    rst_n = 1;
    @(negedge clk);

    set_a_sr = {2'd1, 1'b0, 4'd3}; set_a_pw = {4'd2, 4'd5};
    set_b_sr = {2'd2, 1'b0, 4'd7}; set_b_pw = {4'd9, 4'd1};
    access(0, 0, 1, 5, 3, 0, "R2 set A read");
    access(0, 1, 1, 2, 3, 0, "R2 set A write");
    access(1, 1, 2, 9, 7, 0, "R2 set B write");
    access(1, 0, 2, 1, 7, 0, "R2 set B read");
    access(0, 0, 1, 5, 3, 1, "R2 config change mid-access");

    set_a_sr = {2'd1, 1'b1, 4'd3};
    access(0, 0, 1, 5, 3, 0, "R9 spare bit set");

    set_a_sr = '0; set_a_pw = '0;
    access(0, 0, 0, 0, 0, 0, "min codes read");
    access(0, 1, 0, 0, 0, 0, "min codes write");
    set_b_sr = 7'h7F; set_b_pw = 8'hFF;
    access(1, 0, 3, 15, 15, 0, "max codes read");
    access(1, 1, 3, 15, 15, 0, "max codes write");

    // held request during recovery (R8)
    set_a_sr = {2'd1, 1'b0, 4'd3}; set_a_pw = {4'd2, 4'd5};
    set_b_sr = {2'd2, 1'b0, 4'd7}; set_b_pw = {4'd9, 4'd1};
    req = 1; req_sel = 0; req_wr = 0;
    @(negedge clk); req = 0;
    while (rd_n) @(negedge clk);
    while (!rd_n) @(negedge clk);
    req = 1; req_sel = 1; req_wr = 1;
    #1 chk("R8 no ack during recovery", ack, 0);
    n = 0;
    while (!ack) begin n++; @(negedge clk); #1; end
    chk("R8 held request accepted after recovery", n, 4);
    @(negedge clk); req = 0;
    measure_rest(s, w, r, srd);
    chk("R8 held request setup", s, 3);
    chk("R8 held request write width", w, 10);
    chk("R8 held request recovery", r, 8);

    // trigger on first bus state (R7)
    trig_t1 = 1;
    req = 1; req_sel = 0; req_wr = 0;
    @(negedge clk); req = 0;
    repeat (4) begin
      chk("R7 waiting busy", busy, 1);
      chk("R7 waiting strobes high", rd_n & wr_n, 1);
      @(negedge clk);
    end
    t1_start = 1;
    @(negedge clk); t1_start = 0;
    measure_rest(s, w, r, srd);
    chk("R7 setup after trigger", s, 2);
    chk("R7 read width", w, 6);
    chk("R7 recovery", r, 4);
    trig_t1 = 0;

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule